// File: doc/BRIEF.md
# Triggered ADC Sequencer with Shift Buffers

This block sits between two hardware trigger sources and a successive-approximation converter core that is driven through a start/busy/done/data handshake. A control write enables it. Once enabled, it waits until one of two selection triggers fires. It then starts one conversion on a channel taken from that trigger's programmed pair. Each trigger owns two 3-bit channel fields. Its successive conversions alternate between the two fields.

Every completed result is pushed into a short shift chain owned by the trigger that caused it. Trigger 1's chain is three entries deep and trigger 2's is two entries deep. A separate load strobe per trigger copies that trigger's whole chain into visible result registers in one cycle. Software can then save all results together. A conversion-end interrupt pulse follows every completed conversion. A control write during a conversion aborts it.

The state machine has three states:
- `ST_OFF`: disabled.
- `ST_WAIT`: enabled and waiting for a trigger.
- `ST_CONV`: a conversion is in progress.

Its transitions are:
- *enable*: a control write with the enable bit at 1, from `ST_OFF` to `ST_WAIT`.
- *disable*: a control write with the enable bit at 0, from any state to `ST_OFF`.
- *grant*: a trigger or pending request in `ST_WAIT`, from `ST_WAIT` to `ST_CONV`.
- *complete*: `adc_done` in `ST_CONV`, from `ST_CONV` to `ST_WAIT`.
- *abort*: a control write with the enable bit at 1 in `ST_CONV`, from `ST_CONV` to `ST_WAIT`.

Top module: `adc_trig_seq`

## Requirements
- R1: After reset `enabled`, `busy`, `adc_start`, `conv_irq` and all of `results` are 0. Triggers are ignored while disabled: no `adc_start` and no `busy` follow them. A control write (`cfg_wr`) loads `enabled` from `cfg_en` on the next edge.
- R2: When enabled and idle, a trigger sampled on an edge gives `busy`=1 and a one-cycle `adc_start` pulse on the next cycle. `adc_chan` then holds the selected channel.
- R3: Each trigger alternates its channel: first field `trgN_ch_a`, then field `trgN_ch_b`, and so on. The pointer advances only when a conversion completes.
- R4: A completed trigger-1 conversion shifts chain 1: entry 1 moves to entry 2, entry 0 moves to entry 1, and the new 12-bit result goes into entry 0.
- R5: A completed trigger-2 conversion shifts chain 2: entry 0 (buffer 3) moves to entry 1 (buffer 4), and the new result goes into entry 0.
- R6: `conv_irq` is high for exactly the one cycle after each edge on which `adc_done` completes a conversion, whichever trigger caused it.
- R7: `load1` copies chain 1 into result slots 0..2, and `load2` copies chain 2 into slots 3..4, in one edge. Slot i sits at `results[12*i +: 12]`. A load on the same edge as a push copies the values from before the push. The result slots keep their values otherwise.
- R8: After a completion, `busy` returns to 0, `enabled` stays 1 and the block waits for the next trigger.
- R9: A control write while `busy`=1 stops the conversion. On the next cycle `busy`=0 and `adc_abort` pulses. No push, no interrupt and no pointer advance follow. A later `adc_done` is ignored.
- R10: If both triggers arrive on the same edge, trigger 1 is started. Trigger 2 stays pending and starts on the edge after the first conversion completes.
- R11: A trigger arriving during a conversion is held as pending, at most one per source, and serviced after completion. Any control write clears the pending requests.
- R12: A control write with `cfg_en`=0 resets both channel pointers to the first field and both chains to zero. The result slots are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_en | input | 1 | Enable bit value written with `cfg_wr` |
| trg1_ch_a | input | 3 | Trigger 1 first channel field |
| trg1_ch_b | input | 3 | Trigger 1 second channel field |
| trg2_ch_a | input | 3 | Trigger 2 first channel field |
| trg2_ch_b | input | 3 | Trigger 2 second channel field |
| trig1 | input | 1 | Selection trigger 1 pulse |
| trig2 | input | 1 | Selection trigger 2 pulse |
| load1 | input | 1 | Load strobe publishing chain 1 |
| load2 | input | 1 | Load strobe publishing chain 2 |
| adc_done | input | 1 | Converter end-of-conversion pulse |
| adc_data | input | 12 | Converter result, valid with `adc_done` |
| adc_start | output | 1 | Start pulse to the converter |
| adc_abort | output | 1 | Abort pulse to the converter |
| adc_chan | output | 3 | Channel for the current conversion |
| enabled | output | 1 | Enable status |
| busy | output | 1 | Conversion in progress |
| conv_irq | output | 1 | Conversion-end interrupt pulse |
| results | output | 60 | Five 12-bit result slots, slot i at bits 12*i+11:12*i |

## Verification
The results are due at fixed latencies:
- A trigger sampled on an edge shows as `busy` and `adc_start` one cycle later.
- `conv_irq` appears one cycle after the edge that samples `adc_done`.
- A pending trigger starts one cycle after that interrupt cycle.
- Result slots change on the edge that samples a load strobe.
- An aborting write shows as `busy`=0 with `adc_abort` one cycle later.

The bench drives every input just after a falling edge and samples outputs at the following falling edge. Each check sits exactly the counted number of cycles after its stimulus. The bench tracks pointers, chains and slots in its own model and updates them at those same points.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int RES_W   = 12;
    localparam int CH_W    = 3;
    localparam int DEPTH1  = 3;
    localparam int DEPTH2  = 2;
    localparam int N_SLOTS = DEPTH1 + DEPTH2;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WAIT = 2'd1,
        ST_CONV = 2'd2
    } seq_state_t;
endpackage

// File: rtl/trig_slot.sv
// Per-trigger request latch and alternating channel pointer.
module trig_slot #(
    parameter int CH_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            armed,     // block enabled
    input  logic            clear,     // control write: drop pending
    input  logic            flush,     // disable: pointer to first field
    input  logic            trig_in,
    input  logic            grant,     // request consumed this cycle
    input  logic            commit,    // own conversion completed
    input  logic [CH_W-1:0] ch_a,
    input  logic [CH_W-1:0] ch_b,
    output logic            req,
    output logic [CH_W-1:0] ch_sel
);
    logic pend_q;
    logic ptr_q;
    logic take;

    assign take   = armed & ~clear & trig_in;
    assign req    = pend_q | take;
    assign ch_sel = ptr_q ? ch_b : ch_a;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (clear) begin
            pend_q <= 1'b0;
        end else if (pend_q) begin
            // grant consumes the held request; a fresh one re-arms it
            pend_q <= grant ? take : 1'b1;
        end else begin
            pend_q <= take & ~grant;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= 1'b0;
        end else if (flush) begin
            ptr_q <= 1'b0;
        end else if (commit) begin
            ptr_q <= ~ptr_q;
        end
    end
endmodule

// File: rtl/shift_chain.sv
// Result shift chain with a shadow bank published by a load strobe.
module shift_chain #(
    parameter int DEPTH = 3,
    parameter int W     = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               push,
    input  logic [W-1:0]       din,
    input  logic               load,
    output logic [DEPTH*W-1:0] res_flat
);
    localparam int FLAT_W = DEPTH * W;

    logic [W-1:0] stg_q [DEPTH];
    logic [W-1:0] res_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg_q[i] <= '0;
            end else if (flush) begin
                stg_q[i] <= '0;
            end else if (push) begin
                if (i == 0) begin
                    stg_q[i] <= din;
                end else begin
                    stg_q[i] <= stg_q[(i > 0) ? i - 1 : 0];
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                res_q[i] <= '0;
            end else if (load) begin
                res_q[i] <= stg_q[i];
            end
        end

        assign res_flat[i*W +: W] = res_q[i];
    end

    logic unused_w;
    assign unused_w = (FLAT_W == 0);
endmodule

// File: rtl/seq_fsm.sv
// Sequencing state machine: enable, arbitration, converter handshake.
module seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int CH_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr,
    input  logic            cfg_en,
    input  logic            req1,
    input  logic            req2,
    input  logic [CH_W-1:0] chan1,
    input  logic [CH_W-1:0] chan2,
    input  logic            adc_done,
    output logic            grant1,
    output logic            grant2,
    output logic            commit1,
    output logic            commit2,
    output logic            enabled,
    output logic            busy,
    output logic            adc_start,
    output logic            adc_abort,
    output logic            conv_irq,
    output logic [CH_W-1:0] adc_chan
);
    seq_state_t state_q, state_d;
    logic       sel2_q;       // active conversion belongs to trigger 2
    logic       done_ok;
    logic       abort_now;

    always_comb begin
        state_d   = state_q;
        grant1    = 1'b0;
        grant2    = 1'b0;
        done_ok   = 1'b0;
        abort_now = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                if (cfg_wr && cfg_en) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (cfg_wr) begin
                    state_d = cfg_en ? ST_WAIT : ST_OFF;
                end else if (req1) begin
                    grant1  = 1'b1;
                    state_d = ST_CONV;
                end else if (req2) begin
                    grant2  = 1'b1;
                    state_d = ST_CONV;
                end
            end
            ST_CONV: begin
                if (cfg_wr) begin
                    abort_now = 1'b1;
                    state_d   = cfg_en ? ST_WAIT : ST_OFF;
                end else if (adc_done) begin
                    done_ok = 1'b1;
                    state_d = ST_WAIT;
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    assign commit1 = done_ok & ~sel2_q;
    assign commit2 = done_ok &  sel2_q;
    assign busy    = (state_q == ST_CONV);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enabled   <= 1'b0;
            adc_start <= 1'b0;
            adc_abort <= 1'b0;
            conv_irq  <= 1'b0;
            sel2_q    <= 1'b0;
            adc_chan  <= '0;
        end else begin
            if (cfg_wr) enabled <= cfg_en;
            adc_start <= grant1 | grant2;
            adc_abort <= abort_now;
            conv_irq  <= done_ok;
            if (grant1) begin
                sel2_q   <= 1'b0;
                adc_chan <= chan1;
            end else if (grant2) begin
                sel2_q   <= 1'b1;
                adc_chan <= chan2;
            end
        end
    end
endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq
    import adc_seq_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_wr,
    input  logic                     cfg_en,
    input  logic [CH_W-1:0]          trg1_ch_a,
    input  logic [CH_W-1:0]          trg1_ch_b,
    input  logic [CH_W-1:0]          trg2_ch_a,
    input  logic [CH_W-1:0]          trg2_ch_b,
    input  logic                     trig1,
    input  logic                     trig2,
    input  logic                     load1,
    input  logic                     load2,
    input  logic                     adc_done,
    input  logic [RES_W-1:0]         adc_data,
    output logic                     adc_start,
    output logic                     adc_abort,
    output logic [CH_W-1:0]          adc_chan,
    output logic                     enabled,
    output logic                     busy,
    output logic                     conv_irq,
    output logic [N_SLOTS*RES_W-1:0] results
);
    logic req1, req2, grant1, grant2, commit1, commit2;
    logic [CH_W-1:0] chan1, chan2;
    logic flush;
    logic [DEPTH1*RES_W-1:0] res1;
    logic [DEPTH2*RES_W-1:0] res2;

    assign flush = cfg_wr & ~cfg_en;

    trig_slot #(.CH_W(CH_W)) u_slot1 (
        .clk(clk), .rst_n(rst_n), .armed(enabled), .clear(cfg_wr),
        .flush(flush), .trig_in(trig1), .grant(grant1), .commit(commit1),
        .ch_a(trg1_ch_a), .ch_b(trg1_ch_b), .req(req1), .ch_sel(chan1)
    );

    trig_slot #(.CH_W(CH_W)) u_slot2 (
        .clk(clk), .rst_n(rst_n), .armed(enabled), .clear(cfg_wr),
        .flush(flush), .trig_in(trig2), .grant(grant2), .commit(commit2),
        .ch_a(trg2_ch_a), .ch_b(trg2_ch_b), .req(req2), .ch_sel(chan2)
    );

    seq_fsm #(.CH_W(CH_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en),
        .req1(req1), .req2(req2), .chan1(chan1), .chan2(chan2),
        .adc_done(adc_done), .grant1(grant1), .grant2(grant2),
        .commit1(commit1), .commit2(commit2), .enabled(enabled),
        .busy(busy), .adc_start(adc_start), .adc_abort(adc_abort),
        .conv_irq(conv_irq), .adc_chan(adc_chan)
    );

    shift_chain #(.DEPTH(DEPTH1), .W(RES_W)) u_chain1 (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(commit1),
        .din(adc_data), .load(load1), .res_flat(res1)
    );

    shift_chain #(.DEPTH(DEPTH2), .W(RES_W)) u_chain2 (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(commit2),
        .din(adc_data), .load(load2), .res_flat(res2)
    );

    assign results = {res2, res1};
endmodule

// File: rtl/adc_trig_seq_chk.sv
module adc_trig_seq_chk
    import adc_seq_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic cfg_wr,
    input logic trig1,
    input logic adc_done,
    input logic adc_start,
    input logic adc_abort,
    input logic enabled,
    input logic busy,
    input logic conv_irq
);
    a_r1_off_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        !enabled |=> !adc_start);

    a_r2_trig_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (enabled && !busy && trig1 && !cfg_wr) |=> (busy && adc_start));

    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> busy);

    a_r6_irq_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && adc_done && !cfg_wr) |=> (conv_irq && !busy && enabled));

    a_r6_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        conv_irq |-> $past(busy && adc_done && !cfg_wr));

    a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_wr) |=> (!busy && adc_abort && !conv_irq));
endmodule

bind adc_trig_seq adc_trig_seq_chk u_chk (.*);

// File: tb/tb_adc_trig_seq.sv
`timescale 1ns/1ps
module tb_adc_trig_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 0, cfg_en = 0;
    logic [2:0] trg1_ch_a = 3'd1, trg1_ch_b = 3'd5, trg2_ch_a = 3'd2, trg2_ch_b = 3'd6;
    logic trig1 = 0, trig2 = 0, load1 = 0, load2 = 0, adc_done = 0;
    logic [11:0] adc_data = '0;
    logic adc_start, adc_abort, enabled, busy, conv_irq;
    logic [2:0] adc_chan;
    logic [59:0] results;

    int n_tests = 0, n_fail = 0;
    logic m_ptr1, m_ptr2;
    logic [11:0] m_c1 [3];
    logic [11:0] m_c2 [2];
    logic [11:0] m_res [5];

    always #2 clk = ~clk;

    adc_trig_seq dut (.*);

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_chan(int which);
        if (which == 1) return m_ptr1 ? trg1_ch_b : trg1_ch_a;
        return m_ptr2 ? trg2_ch_b : trg2_ch_a;
    endfunction

    task automatic model_clear();
        m_ptr1 = 0; m_ptr2 = 0;
        foreach (m_c1[i]) m_c1[i] = '0;
        foreach (m_c2[i]) m_c2[i] = '0;
    endtask

    task automatic cfg_write(logic en);
        cfg_wr = 1; cfg_en = en;
        @(negedge clk);
        cfg_wr = 0;
        if (!en) model_clear();
    endtask

    task automatic pulse_trig(logic t1, logic t2);
        trig1 = t1; trig2 = t2;
        @(negedge clk);
        trig1 = 0; trig2 = 0;
    endtask

    task automatic expect_start(int which, string tag);
        chk({tag, " busy"}, busy, 1);
        chk({tag, " start"}, adc_start, 1);
        chk({tag, " chan"}, adc_chan, exp_chan(which));
    endtask

    task automatic finish(int which, logic [11:0] d, int dly);
        repeat (dly) @(negedge clk);
        adc_done = 1; adc_data = d;
        @(negedge clk);
        adc_done = 0;
        chk("R6 irq", conv_irq, 1);
        chk("R8 idle", busy, 0);
        chk("R8 enabled", enabled, 1);
        if (which == 1) begin
            m_c1[2] = m_c1[1]; m_c1[1] = m_c1[0]; m_c1[0] = d; m_ptr1 = ~m_ptr1;
        end else begin
            m_c2[1] = m_c2[0]; m_c2[0] = d; m_ptr2 = ~m_ptr2;
        end
    endtask

    task automatic check_results(string tag);
        for (int i = 0; i < 5; i++) chk(tag, results[12*i +: 12], m_res[i]);
    endtask

    task automatic do_load(logic l1, logic l2, string tag);
        load1 = l1; load2 = l2;
        @(negedge clk);
        load1 = 0; load2 = 0;
        if (l1) for (int i = 0; i < 3; i++) m_res[i] = m_c1[i];
        if (l2) for (int i = 0; i < 2; i++) m_res[3+i] = m_c2[i];
        check_results(tag);
    endtask

    initial begin
        void'($urandom(32'd4242));
        model_clear();
        foreach (m_res[i]) m_res[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 enabled", enabled, 0);
        chk("R1 busy", busy, 0);
        chk("R1 irq", conv_irq, 0);
        chk("R1 results", results, 0);
        pulse_trig(1, 1);
        chk("R1 ignored busy", busy, 0);
        chk("R1 ignored start", adc_start, 0);
        cfg_write(1);
        chk("R1 enable", enabled, 1);

        // R2 R3 R4 alternating trigger 1 and chain shift
        pulse_trig(1, 0); expect_start(1, "R2 R3 t1 first");
        finish(1, 12'h111, 2);
        pulse_trig(1, 0); expect_start(1, "R3 t1 second");
        finish(1, 12'h222, 1);
        pulse_trig(1, 0); expect_start(1, "R3 t1 third");
        finish(1, 12'h333, 3);
        do_load(1, 0, "R4 R7 chain1");
        // R5 trigger 2 chain
        pulse_trig(0, 1); expect_start(2, "R5 t2 first");
        finish(2, 12'hA01, 1);
        pulse_trig(0, 1); expect_start(2, "R3 t2 second");
        finish(2, 12'hA02, 2);
        do_load(0, 1, "R5 R7 chain2");

        // R10 simultaneous triggers
        pulse_trig(1, 1); expect_start(1, "R10 t1 wins");
        finish(1, 12'h444, 2);
        @(negedge clk); expect_start(2, "R10 t2 pending");
        finish(2, 12'hA03, 1);

        // R11 repeated trigger during conversion: one pending only
        pulse_trig(1, 0); expect_start(1, "R11 first");
        pulse_trig(1, 0); pulse_trig(1, 0);
        finish(1, 12'h555, 1);
        @(negedge clk); expect_start(1, "R11 pending");
        finish(1, 12'h666, 1);
        @(negedge clk);
        chk("R11 single pending", busy, 0);

        // R7 load on same edge as push copies pre-push values
        pulse_trig(0, 1); expect_start(2, "R7 push");
        adc_done = 1; adc_data = 12'hBEE; load2 = 1;
        @(negedge clk);
        adc_done = 0; load2 = 0;
        for (int i = 0; i < 2; i++) m_res[3+i] = m_c2[i];
        m_c2[1] = m_c2[0]; m_c2[0] = 12'hBEE; m_ptr2 = ~m_ptr2;
        chk("R7 irq", conv_irq, 1);
        check_results("R7 same edge");
        do_load(1, 1, "R7 both");

        // R9 abort: discard, no irq, pointer unchanged, late done ignored
        pulse_trig(1, 0); expect_start(1, "R9 start");
        pulse_trig(0, 1);
        cfg_write(1);
        chk("R9 busy", busy, 0);
        chk("R9 abort", adc_abort, 1);
        chk("R9 irq", conv_irq, 0);
        adc_done = 1; adc_data = 12'hDEA;
        @(negedge clk);
        adc_done = 0;
        chk("R9 late done irq", conv_irq, 0);
        chk("R11 pending cleared", busy, 0);
        do_load(1, 1, "R9 nothing pushed");
        pulse_trig(1, 0); expect_start(1, "R9 pointer kept");
        finish(1, 12'h777, 1);

        // R12 disable clears pointers and chains, keeps results
        pulse_trig(0, 1); expect_start(2, "R12 pre");
        finish(2, 12'hA04, 1);
        cfg_write(0);
        chk("R12 disabled", enabled, 0);
        check_results("R12 results kept");
        pulse_trig(1, 0);
        chk("R1 off trig", busy, 0);
        cfg_write(1);
        pulse_trig(1, 0); expect_start(1, "R12 ptr1 reset");
        finish(1, 12'h888, 1);
        pulse_trig(0, 1); expect_start(2, "R12 ptr2 reset");
        finish(2, 12'hA05, 1);
        do_load(1, 1, "R12 chains cleared");

        // random mix
        for (int k = 0; k < 60; k++) begin
            int w;
            w = ($urandom % 2) + 1;
            if (w == 1) pulse_trig(1, 0); else pulse_trig(0, 1);
            expect_start(w, "R2 R3 random");
            finish(w, 12'($urandom), ($urandom % 4) + 1);
            if ($urandom % 3 == 0) do_load($urandom % 2 == 0, 1'b1, "R7 random");
        end
        do_load(1, 1, "R4 R5 final");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule